// File: doc/BRIEF.md
# Endpoint Register Update Lock Controller

This block holds the mode register and the byte-count register of one USB device endpoint. It keeps them coherent between the serial interface engine (SIE), which produces transaction events, and the CPU, which reaches them over a simple register bus. When the SIE reports an update, the block loads new mode and count values from the SIE. It may also raise the endpoint interrupt flag. It then refuses CPU writes to each changed register until the CPU has read that register. This ensures that firmware never overwrites a hardware change it has not seen.

A setup event sets the top bit of the mode register (the setup bit) and opens a window that lasts until the SIE signals the end of the control-write data phase. While the window is open, the setup bit is held at 1 whatever the CPU writes. Hardware events always take priority over CPU accesses made in the same cycle.

Top module: `ep_reg_lock`

## Requirements
- R1: A cycle with `sie_setup_i` high sets mode bit DATA_W-1 (the setup bit) to 1 and locks the mode register from the next cycle.
- R2: From a setup event until a cycle with `sie_data_end_i` high (and no setup), the setup bit stays 1 even when an unlocked CPU write carries 0 there. Once the window is closed, an unlocked write can clear the bit.
- R3: A cycle with `sie_update_i` high locks both the mode and count registers from the next cycle.
- R4: A CPU write (`cpu_wr_i`) to a locked register has no effect. A write to an unlocked register loads `cpu_wdata_i` on the next cycle, unless a hardware event touches that register in the same cycle.
- R5: A CPU read (`cpu_rd_i`) of address 0 unlocks only the mode register, and a read of address 1 unlocks only the count register. A read in the same cycle as an event that locks the register leaves it locked, and a read made before an update does not prevent the lock.
- R6: An update loads every mode bit except the setup bit from `sie_mode_i` and the full count from `sie_cnt_i`. The setup bit keeps its value, or is held at 1 by a setup event or an open window.
- R7: An update with `sie_irq_req_i` high sets `irq_o`. A CPU write to address 2 with data bit 0 set clears it, and a set in the same cycle wins over the clear.
- R8: While `rst_ni` is low, both registers read 0, both registers are unlocked, `irq_o` is 0 and the setup window is closed.
- R9: `cpu_rdata_o` presents address 0 as mode and address 1 as count. Address 2 is status, with bit 0 = irq flag, bit 1 = mode lock, bit 2 = count lock, bit 3 = setup window and the other bits 0. Address 3 reads 0. Reading status unlocks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sie_setup_i | input | 1 | Setup event strobe |
| sie_update_i | input | 1 | Update event strobe |
| sie_data_end_i | input | 1 | End of control-write data phase |
| sie_irq_req_i | input | 1 | Transaction requests an interrupt (used with update) |
| sie_mode_i | input | DATA_W | Mode value from SIE |
| sie_cnt_i | input | DATA_W | Count value from SIE |
| cpu_addr_i | input | 2 | Register address |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | Read data for current address |
| mode_o | output | DATA_W | Current mode register |
| cnt_o | output | DATA_W | Current count register |
| irq_o | output | 1 | Endpoint interrupt flag |

## Verification
The assertions assume that the event strobes are single-cycle pulses, that `cpu_rd_i` and `cpu_wr_i` are never high together, and that `sie_irq_req_i` has meaning only alongside an update. The bench drives each strobe for exactly one cycle and never asserts both CPU strobes at once. It deliberately places events in the same cycle as reads and writes, because those collisions are where the priority rules matter. It also places `sie_data_end_i` after the setup window has opened.

// File: rtl/ep_lock_pkg.sv
package ep_lock_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 2'd0,
    A_CNT  = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
  localparam int NUM_LOCK = 2;
  localparam int L_MODE = 0;
  localparam int L_CNT  = 1;
endpackage

// File: rtl/ep_lock_tracker.sv
module ep_lock_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_evt_i,
  input  logic cpu_rd_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       locked_o <= 1'b0;
    else if (hw_evt_i) locked_o <= 1'b1;
    else if (cpu_rd_i) locked_o <= 1'b0;
  end

  AST_LOCK_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_evt_i |=> locked_o); // R3
  AST_READ_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && !hw_evt_i |=> !locked_o); // R5
endmodule

// File: rtl/ep_setup_window.sv
module ep_setup_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_i,
  input  logic data_end_i,
  output logic open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         open_o <= 1'b0;
    else if (setup_i)    open_o <= 1'b1;
    else if (data_end_i) open_o <= 1'b0;
  end

  AST_WIN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> open_o); // R2
endmodule

// File: rtl/ep_irq_flag.sv
module ep_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R7
endmodule

// File: rtl/ep_reg_lock.sv
module ep_reg_lock
  import ep_lock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sie_setup_i,
  input  logic              sie_update_i,
  input  logic              sie_data_end_i,
  input  logic              sie_irq_req_i,
  input  logic [DATA_W-1:0] sie_mode_i,
  input  logic [DATA_W-1:0] sie_cnt_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  localparam int SB = DATA_W - 1;

  logic [DATA_W-1:0]   mode_q, mode_d, cnt_q, cnt_d;
  logic [NUM_LOCK-1:0] lock_evt, lock_rd, locked;
  logic                win_q;
  reg_addr_e           addr;

  assign addr = reg_addr_e'(cpu_addr_i);

  assign lock_evt[L_MODE] = sie_setup_i | sie_update_i;
  assign lock_evt[L_CNT]  = sie_update_i;
  assign lock_rd[L_MODE]  = cpu_rd_i && (addr == A_MODE);
  assign lock_rd[L_CNT]   = cpu_rd_i && (addr == A_CNT);

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
    ep_lock_tracker i_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hw_evt_i (lock_evt[g]),
      .cpu_rd_i (lock_rd[g]),
      .locked_o (locked[g])
    );
  end

  ep_setup_window i_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .setup_i    (sie_setup_i),
    .data_end_i (sie_data_end_i),
    .open_o     (win_q)
  );

  ep_irq_flag i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sie_update_i && sie_irq_req_i),
    .clr_i  (cpu_wr_i && (addr == A_STAT) && cpu_wdata_i[0]),
    .flag_o (irq_o)
  );

  always_comb begin
    mode_d = mode_q;
    if (cpu_wr_i && addr == A_MODE && !locked[L_MODE] && !lock_evt[L_MODE])
      mode_d = cpu_wdata_i;
    if (sie_update_i) begin
      mode_d     = sie_mode_i;
      mode_d[SB] = mode_q[SB];
    end
    if (sie_setup_i || win_q) mode_d[SB] = 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (sie_update_i) cnt_d = sie_cnt_i;
    else if (cpu_wr_i && addr == A_CNT && !locked[L_CNT]) cnt_d = cpu_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    unique case (addr)
      A_MODE: cpu_rdata_o = mode_q;
      A_CNT:  cpu_rdata_o = cnt_q;
      A_STAT: cpu_rdata_o[3:0] = {win_q, locked[L_CNT], locked[L_MODE], irq_o};
      default: cpu_rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  AST_SETUP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_setup_i |=> mode_q[SB] && locked[L_MODE]); // R1
  AST_WIN_HOLDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q |-> mode_q[SB]); // R2
  AST_MODE_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked[L_MODE] && !sie_setup_i && !sie_update_i |=> $stable(mode_q)); // R4
  AST_CNT_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked[L_CNT] && !sie_update_i |=> $stable(cnt_q)); // R4
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_update_i |=> cnt_q == $past(sie_cnt_i)); // R6
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_update_i |=> mode_q[SB-1:0] == $past(sie_mode_i[SB-1:0])); // R6
endmodule

// File: tb/test_ep_reg_lock.sv
module test_ep_reg_lock;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic setup = 0, update = 0, dend = 0, ireq = 0, rd = 0, wr = 0;
  logic [W-1:0] smode = 0, scnt = 0, wdata = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] rdata, mode, cnt;
  logic irq;
  int checks = 0, errors = 0;
  string tag = "R8";
  // reference model state
  logic [W-1:0] m_mode, m_cnt;
  logic m_irq, m_ml, m_cl, m_win;

  always #4 clk = ~clk;

  ep_reg_lock #(.DATA_W(W)) i_ep_reg_lock (
    .clk_i(clk), .rst_ni(rst_n), .sie_setup_i(setup), .sie_update_i(update),
    .sie_data_end_i(dend), .sie_irq_req_i(ireq), .sie_mode_i(smode), .sie_cnt_i(scnt),
    .cpu_addr_i(addr), .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .mode_o(mode), .cnt_o(cnt), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_irq = 0; m_ml = 0; m_cl = 0; m_win = 0;
    end else begin
      logic [W-1:0] nm, nc;
      logic nml, ncl, nirq, nwin;
      nm = m_mode; nc = m_cnt;
      if (wr && addr == 0 && !m_ml && !setup && !update) nm = wdata;
      if (update) nm = {m_mode[W-1], smode[W-2:0]};
      if (setup || m_win) nm[W-1] = 1'b1;
      if (update) nc = scnt;
      else if (wr && addr == 1 && !m_cl) nc = wdata;
      nml  = (setup || update) ? 1'b1 : (rd && addr == 0) ? 1'b0 : m_ml;
      ncl  = update ? 1'b1 : (rd && addr == 1) ? 1'b0 : m_cl;
      nirq = (update && ireq) ? 1'b1 : (wr && addr == 2 && wdata[0]) ? 1'b0 : m_irq;
      nwin = setup ? 1'b1 : dend ? 1'b0 : m_win;
      m_mode = nm; m_cnt = nc; m_ml = nml; m_cl = ncl; m_irq = nirq; m_win = nwin;
    end
  end

  function automatic logic [W-1:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return m_cnt;
      2'd2: return {4'b0, m_win, m_cl, m_ml, m_irq};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({tag, " mode"}, mode, m_mode);
    chk({tag, " cnt"}, cnt, m_cnt);
    chk({tag, " irq"}, W'(irq), W'(m_irq));
    chk({tag, " rdata"}, rdata, m_rdata(addr));
  endtask

  task automatic tick();
    @(posedge clk); #2;
    compare_all();
    setup = 0; update = 0; dend = 0; ireq = 0; rd = 0; wr = 0;
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr = 1; tick();
  endtask
  task automatic cpu_rd(input logic [1:0] a);
    addr = a; rd = 1; tick();
  endtask
  task automatic sie_upd(input logic [W-1:0] m, input logic [W-1:0] c, input logic i);
    smode = m; scnt = c; ireq = i; update = 1; tick();
  endtask
  task automatic see_stat(input logic [3:0] exp, input string t);
    addr = 2; #1; chk({t, " status"}, rdata, W'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R8";
    repeat (2) @(posedge clk); #2;
    chk("R8 mode", mode, 0); chk("R8 cnt", cnt, 0); chk("R8 irq", W'(irq), 0);
    see_stat(4'b0000, "R8");
    rst_n = 1; tick();
    tag = "R4";
    cpu_wr(0, 8'h35); cpu_wr(1, 8'h0c);
    chk("R4 unlocked write mode", mode, 8'h35);
    tag = "R6";
    sie_upd(8'h4a, 8'h40, 1'b1);
    chk("R6 count load", cnt, 8'h40);
    chk("R6 mode load keeps setup bit", mode, 8'h4a);
    chk("R7 irq set", W'(irq), 1);
    see_stat(4'b0111, "R3");
    tag = "R4";
    cpu_wr(0, 8'hff); cpu_wr(1, 8'h11);
    chk("R4 locked mode write dropped", mode, 8'h4a);
    tag = "R9";
    cpu_rd(2); see_stat(4'b0111, "R9 status read unlocks nothing");
    cpu_rd(3); chk("R9 addr3", rdata, 0);
    tag = "R5";
    cpu_rd(1); cpu_wr(1, 8'h22); cpu_wr(0, 8'h01);
    chk("R5 only cnt unlocked", cnt, 8'h22);
    chk("R5 mode still locked", mode, 8'h4a);
    cpu_rd(0); cpu_wr(0, 8'h07);
    chk("R5 mode unlocked by read", mode, 8'h07);
    cpu_rd(0); sie_upd(8'h12, 8'h05, 1'b0);
    see_stat(4'b0111, "R5 earlier read does not prevent lock");
    addr = 0; rd = 1; smode = 8'h13; scnt = 8'h06; update = 1; tick();
    see_stat(4'b0111, "R5 read with update stays locked");
    tag = "R7";
    cpu_wr(2, 8'h01); chk("R7 irq cleared", W'(irq), 0);
    sie_upd(8'h14, 8'h07, 1'b1);
    addr = 2; wdata = 8'h01; wr = 1; smode = 8'h14; scnt = 8'h08; ireq = 1; update = 1; tick();
    chk("R7 set wins over clear", W'(irq), 1);
    cpu_wr(2, 8'h01);
    tag = "R1";
    cpu_rd(0); cpu_rd(1);
    setup = 1; addr = 0; rd = 1; tick();
    chk("R1 setup bit set", mode, 8'h94);
    see_stat(4'b1010, "R1 lock and window");
    tag = "R2";
    cpu_rd(0); cpu_wr(0, 8'h00);
    chk("R2 setup bit held", mode, 8'h80);
    tag = "R6";
    sie_upd(8'h33, 8'h09, 1'b0);
    chk("R6 update keeps setup bit", mode, 8'hb3);
    tag = "R2";
    cpu_rd(0); dend = 1; tick(); cpu_wr(0, 8'h00);
    chk("R2 cleared after window", mode, 8'h00);
    tag = "R4";
    addr = 0; wr = 1; wdata = 8'h5a; setup = 1; tick();
    chk("R4 write with setup dropped", mode, 8'h80);
    tag = "R9";
    for (int i = 0; i < 20; i++) begin
      smode = W'(i * 37); scnt = W'(i * 11); ireq = i[0];
      update = (i % 3 == 0); setup = (i % 7 == 2); dend = (i % 5 == 4);
      addr = 2'(i); rd = i[1]; wr = !i[1]; wdata = W'(i * 53);
      tick();
    end
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule